// File: doc/BRIEF.md
# NEC Infrared Remote Receiver

This block decodes the output of an infrared demodulator carrying NEC remote-control frames. The input `ir_in` is high while the carrier is present (a mark) and low otherwise. A prescaler divides the system clock into sample ticks. The block measures the width of every mark and space in ticks. It recognises the long leader burst and then collects 32 data bits, least significant bit first.

A complete frame passes two checks. The command byte must be the bitwise inverse of the inverted-command byte. When address checking is turned on, the 16-bit address must also equal a programmed system code. A frame that passes is latched into the code register and sets the interrupt status. A repeat frame (leader mark, short space, stop mark) does not change the code. Instead it raises a repeat flag and sets the status.

The decoder is a state machine with seven states:

| State | Meaning |
|---|---|
| `S_IDLE` | Waiting for a mark |
| `S_LEAD_MARK` | Measuring the leader mark |
| `S_LEAD_SPACE` | Measuring the space after the leader |
| `S_BIT_MARK` | Measuring the mark that starts a bit |
| `S_BIT_SPACE` | Measuring the space that gives the bit value |
| `S_STOP_MARK` | Measuring the mark that ends a data frame |
| `S_REP_MARK` | Measuring the mark that ends a repeat frame |

The transitions are:
- `S_IDLE` goes to `S_LEAD_MARK` on a rising edge.
- `S_LEAD_MARK` goes to `S_LEAD_SPACE` when the mark width is in its window.
- `S_LEAD_SPACE` goes to `S_BIT_MARK` on a long space, or to `S_REP_MARK` on a short space.
- `S_BIT_MARK` goes to `S_BIT_SPACE`.
- `S_BIT_SPACE` goes back to `S_BIT_MARK`, or to `S_STOP_MARK` after the 32nd bit.
- `S_STOP_MARK` and `S_REP_MARK` return to `S_IDLE` once the closing mark ends.
- Any width outside its window, any overlong segment, and a low enable all force `S_IDLE`.

Top module: `nec_ir_rx`

## Requirements
- R1: After reset, `code_out` is 0 and `rep_flag`, `irq_stat` and `irq` are all low.
- R2: Each width is measured in sample ticks of `TICK_DIV` clocks. The nominal widths are: leader mark 160, leader space 80, repeat space 40, bit or stop mark 10, zero space 10, one space 30. A width w with nominal n is accepted when n - n/4 <= w <= n + n/4.
- R3: Received bit k (k = 0 first) is placed at bit k of a 32-bit word W. W[15:0] is the address, W[23:16] the command and W[31:24] the inverted command.
- R4: A frame whose command is not the bitwise inverse of its inverted-command byte is discarded, and `code_out` and `irq_stat` keep their values.
- R5: With `sys_chk_en` high, a frame whose address differs from `sys_code` is discarded. With it low, the address is not compared.
- R6: A repeat frame (leader mark, repeat space, stop mark) sets `rep_flag` and `irq_stat` and leaves `code_out` unchanged. A later accepted frame clears `rep_flag`.
- R7: Any mark or space outside its window returns the decoder to idle without a result. The next well-formed frame is then decoded normally.
- R8: `irq_stat` is set by an accepted frame or a repeat frame, and is cleared by `irq_ack` (a set in the same cycle wins). `irq` is `irq_stat` gated by `irq_en`.
- R9: While `rx_en` is low the decoder stays idle, and frames have no effect on any output.
- R10: An accepted frame loads `code_out` as {address, command, inverted command}, so the command is in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR input, 1 = mark |
| rx_en | input | 1 | Receiver enable |
| sys_chk_en | input | 1 | Enable the system-code comparison |
| sys_code | input | 16 | Expected address |
| irq_en | input | 1 | Interrupt mask, 1 = pass |
| irq_ack | input | 1 | Clears the interrupt status |
| code_out | output | 32 | Last accepted code |
| rep_flag | output | 1 | Repeat frame seen |
| irq_stat | output | 1 | Interrupt status |
| irq | output | 1 | Masked interrupt request |

## Verification
The result is due three clock edges after the input falls at the end of the stop mark. Two edges are spent in the input synchroniser and one in the result registers. The bench therefore holds the input low for sixteen cycles after each frame before it samples `code_out`, `rep_flag`, `irq_stat` and `irq`. No further edge arrives in that interval, so the sample always falls after the update and before any later change. The clear by `irq_ack` takes effect at the next edge, and the bench samples it one cycle later on the falling clock edge.

// File: rtl/nec_ir_pkg.sv
package nec_ir_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD_MARK,
        S_LEAD_SPACE,
        S_BIT_MARK,
        S_BIT_SPACE,
        S_STOP_MARK,
        S_REP_MARK
    } rx_state_e;

    // Upper bound of the +/-25 % window around a nominal width
    function automatic int unsigned win_hi(input int unsigned nom);
        return nom + nom / 4;
    endfunction

    function automatic logic in_window(input int unsigned w, input int unsigned nom);
        return (w >= nom - nom / 4) && (w <= win_hi(nom));
    endfunction

endpackage

// File: rtl/nec_tick_gen.sv
module nec_tick_gen #(
    parameter int unsigned DIV = 2812
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/nec_seg_timer.sv
module nec_seg_timer #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_in,
    input  logic             tick,
    output logic             level,
    output logic             edge_hit,
    output logic [CNT_W-1:0] width
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ir_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level    = s2;
    assign edge_hit = s2 ^ s3;

    // Ticks elapsed since the last level change, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            width <= '0;
        else if (edge_hit)
            width <= '0;
        else if (tick && !(&width))
            width <= width + 1'b1;
    end

endmodule

// File: rtl/nec_fsm.sv
module nec_fsm
    import nec_ir_pkg::*;
#(
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned T_LEAD_MARK = 160,
    parameter int unsigned T_LEAD_SPC  = 80,
    parameter int unsigned T_REP_SPC   = 40,
    parameter int unsigned T_BIT_MARK  = 10,
    parameter int unsigned T_ZERO_SPC  = 10,
    parameter int unsigned T_ONE_SPC   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             level,
    input  logic             edge_hit,
    input  logic [CNT_W-1:0] width,
    output logic [31:0]      frame_bits,
    output logic             frame_done,
    output logic             rep_done
);
    localparam int unsigned NBITS = 32;
    localparam int unsigned BCW   = $clog2(NBITS);

    rx_state_e      state, nxt;
    logic [BCW-1:0] bit_cnt;
    logic           shift_en, bit_val, too_long;
    int unsigned    w, lim;

    assign w = 32'(width);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            bit_cnt    <= '0;
            frame_bits <= '0;
        end else begin
            state <= nxt;
            if (state == S_LEAD_SPACE)
                bit_cnt <= '0;
            else if (shift_en)
                bit_cnt <= bit_cnt + 1'b1;
            if (shift_en)
                frame_bits <= {bit_val, frame_bits[31:1]};
        end
    end

    // Longest width allowed in the current segment
    always_comb begin
        unique case (state)
            S_LEAD_MARK:  lim = win_hi(T_LEAD_MARK);
            S_LEAD_SPACE: lim = win_hi(T_LEAD_SPC);
            S_BIT_SPACE:  lim = win_hi(T_ONE_SPC);
            default:      lim = win_hi(T_BIT_MARK);
        endcase
        too_long = (state != S_IDLE) && (w > lim);
    end

    always_comb begin
        nxt      = state;
        shift_en = 1'b0;
        bit_val  = 1'b0;
        if (!enable) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:
                    if (edge_hit && level) nxt = S_LEAD_MARK;
                S_LEAD_MARK:
                    if (edge_hit)
                        nxt = in_window(w, T_LEAD_MARK) ? S_LEAD_SPACE : S_IDLE;
                    else if (too_long)
                        nxt = S_IDLE;
                S_LEAD_SPACE:
                    if (edge_hit) begin
                        if (in_window(w, T_LEAD_SPC))     nxt = S_BIT_MARK;
                        else if (in_window(w, T_REP_SPC)) nxt = S_REP_MARK;
                        else                              nxt = S_IDLE;
                    end else if (too_long)
                        nxt = S_IDLE;
                S_BIT_MARK:
                    if (edge_hit)
                        nxt = in_window(w, T_BIT_MARK) ? S_BIT_SPACE : S_IDLE;
                    else if (too_long)
                        nxt = S_IDLE;
                S_BIT_SPACE:
                    if (edge_hit) begin
                        if (in_window(w, T_ZERO_SPC) || in_window(w, T_ONE_SPC)) begin
                            shift_en = 1'b1;
                            bit_val  = in_window(w, T_ONE_SPC);
                            nxt = (bit_cnt == BCW'(NBITS - 1)) ? S_STOP_MARK : S_BIT_MARK;
                        end else
                            nxt = S_IDLE;
                    end else if (too_long)
                        nxt = S_IDLE;
                S_STOP_MARK, S_REP_MARK:
                    if (edge_hit || too_long) nxt = S_IDLE;
                default:
                    nxt = S_IDLE;
            endcase
        end
    end

    // Result pulses
    always_comb begin
        frame_done = enable && edge_hit && (state == S_STOP_MARK) && in_window(w, T_BIT_MARK);
        rep_done   = enable && edge_hit && (state == S_REP_MARK)  && in_window(w, T_BIT_MARK);
    end

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == S_IDLE); // R9
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && rep_done)); // R6
    AST_STOP_AFTER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIT_SPACE && nxt == S_STOP_MARK) |=> bit_cnt == '0); // R3

endmodule

// File: rtl/nec_ir_rx.sv
module nec_ir_rx #(
    parameter int unsigned TICK_DIV    = 2812,
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned T_LEAD_MARK = 160,
    parameter int unsigned T_LEAD_SPC  = 80,
    parameter int unsigned T_REP_SPC   = 40,
    parameter int unsigned T_BIT_MARK  = 10,
    parameter int unsigned T_ZERO_SPC  = 10,
    parameter int unsigned T_ONE_SPC   = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        rx_en,
    input  logic        sys_chk_en,
    input  logic [15:0] sys_code,
    input  logic        irq_en,
    input  logic        irq_ack,
    output logic [31:0] code_out,
    output logic        rep_flag,
    output logic        irq_stat,
    output logic        irq
);
    logic             tick, level, edge_hit, frame_done, rep_done, accept;
    logic [CNT_W-1:0] width;
    logic [31:0]      fbits;
    logic [15:0]      f_addr;
    logic [7:0]       f_cmd, f_icmd;

    nec_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    nec_seg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .tick(tick),
        .level(level), .edge_hit(edge_hit), .width(width)
    );

    nec_fsm #(
        .CNT_W(CNT_W), .T_LEAD_MARK(T_LEAD_MARK), .T_LEAD_SPC(T_LEAD_SPC),
        .T_REP_SPC(T_REP_SPC), .T_BIT_MARK(T_BIT_MARK),
        .T_ZERO_SPC(T_ZERO_SPC), .T_ONE_SPC(T_ONE_SPC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(rx_en), .level(level),
        .edge_hit(edge_hit), .width(width), .frame_bits(fbits),
        .frame_done(frame_done), .rep_done(rep_done)
    );

    assign f_addr = fbits[15:0];
    assign f_cmd  = fbits[23:16];
    assign f_icmd = fbits[31:24];

    assign accept = frame_done && (f_cmd == ~f_icmd) &&
                    (!sys_chk_en || (f_addr == sys_code));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_out <= '0;
            rep_flag <= 1'b0;
            irq_stat <= 1'b0;
        end else begin
            if (accept) begin
                code_out <= {f_addr, f_cmd, f_icmd};
                rep_flag <= 1'b0;
            end else if (rep_done) begin
                rep_flag <= 1'b1;
            end
            if (accept || rep_done)
                irq_stat <= 1'b1;
            else if (irq_ack)
                irq_stat <= 1'b0;
        end
    end

    assign irq = irq_stat & irq_en;

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(code_out)); // R4
    AST_REP_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rep_done |=> $stable(code_out) && rep_flag); // R6
    AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat) |-> $past(accept || rep_done)); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !accept && !rep_done) |=> !irq_stat); // R8

endmodule

// File: tb/tb_nec_ir_rx.sv
module tb_nec_ir_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;

    logic        clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0;
    logic        rx_en = 1'b0, sys_chk_en = 1'b0, irq_en = 1'b1, irq_ack = 1'b0;
    logic [15:0] sys_code = '0;
    logic [31:0] code_out;
    logic        rep_flag, irq_stat, irq;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] exp_code = '0;
    logic        exp_rep = 1'b0, exp_stat = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nec_ir_rx #(.TICK_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .rx_en(rx_en),
        .sys_chk_en(sys_chk_en), .sys_code(sys_code), .irq_en(irq_en),
        .irq_ack(irq_ack), .code_out(code_out), .rep_flag(rep_flag),
        .irq_stat(irq_stat), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "code_out", code_out, exp_code);
        chk(req, "rep_flag", 32'(rep_flag), 32'(exp_rep));
        chk(req, "irq_stat", 32'(irq_stat), 32'(exp_stat));
        chk(req, "irq", 32'(irq), 32'(exp_stat & irq_en));
    endtask

    task automatic seg(input logic lvl, input int ticks);
        ir_in = lvl;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    task automatic finish_frame();
        seg(1'b1, 10);
        ir_in = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    // space_bad: index of a bit whose space is given an illegal width (-1 = none)
    task automatic send_frame(input logic [31:0] w, input int lead_mark, input int space_bad);
        seg(1'b1, lead_mark);
        seg(1'b0, 80);
        for (int i = 0; i < 32; i++) begin
            seg(1'b1, 10);
            seg(1'b0, (i == space_bad) ? 20 : (w[i] ? 30 : 10));
        end
        finish_frame();
    endtask

    task automatic send_rep();
        seg(1'b1, 160);
        seg(1'b0, 40);
        finish_frame();
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        exp_stat = 1'b0;
        chk("R8", "irq_stat after ack", 32'(irq_stat), 32'(0));
    endtask

    function automatic logic frame_ok(input logic [31:0] w, input logic chk_en, input logic [15:0] sc);
        return (w[23:16] == ~w[31:24]) && (!chk_en || (w[15:0] == sc));
    endfunction

    function automatic logic [31:0] code_of(input logic [31:0] w);
        return {w[15:0], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] mk(input logic [15:0] a, input logic [7:0] c);
        return {~c, c, a};
    endfunction

    task automatic apply(input logic [31:0] w, input string req);
        send_frame(w, 160, -1);
        if (rx_en && frame_ok(w, sys_chk_en, sys_code)) begin
            exp_code = code_of(w);
            exp_rep  = 1'b0;
            exp_stat = 1'b1;
        end
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (5) @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R1");

        // R3 / R10 directed: address 0x00FF, command 0x12
        apply(mk(16'h00ff, 8'h12), "R3");
        chk("R10", "command field", 32'(code_out[15:8]), 32'h12);
        ack();

        // R6 repeat frame, then cleared by a full frame
        send_rep();
        exp_rep = 1'b1; exp_stat = 1'b1;
        check_all("R6");
        apply(mk(16'h1234, 8'h5a), "R6");
        ack();

        // R4 bad inverse
        apply({8'h00, 8'h33, 16'h4444}, "R4");

        // R2 / R7 timing violations, then a good frame
        send_frame(mk(16'h7777, 8'h01), 110, -1);
        check_all("R7");
        send_frame(mk(16'h7777, 8'h02), 160, 5);
        check_all("R2");
        apply(mk(16'h7777, 8'h03), "R7");
        ack();

        // R8 masked interrupt
        irq_en = 1'b0;
        apply(mk(16'h0101, 8'h44), "R8");
        irq_en = 1'b1;
        #1 chk("R8", "irq unmasked", 32'(irq), 32'(1));
        ack();

        // R9 disabled receiver
        rx_en = 1'b0;
        send_frame(mk(16'h9999, 8'h99), 160, -1);
        check_all("R9");
        send_rep();
        check_all("R9");
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // Random frames
        for (int n = 0; n < 18; n++) begin
            logic [15:0] a = 16'($urandom);
            logic [7:0]  c = 8'($urandom);
            logic [31:0] w = mk(a, c);
            int mode = int'($urandom % 4);
            string req = "R3";
            sys_chk_en = 1'b0;
            if (mode == 1) begin
                w[31:24] = w[31:24] ^ (8'd1 << ($urandom % 8));
                req = "R4";
            end else if (mode == 2) begin
                sys_chk_en = 1'b1; sys_code = a ^ 16'h0100; req = "R5";
            end else if (mode == 3) begin
                sys_chk_en = 1'b1; sys_code = a; req = "R5";
            end
            apply(w, req);
            if (exp_stat) ack();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule